// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block serves one transmit channel. It walks a circular ring of four-word buffer descriptors that sit in a word-addressed memory. When the channel scheduler offers a slot and no buffer is loaded, the block reads the descriptor at the current ring position. If the device owns that descriptor, the block copies the buffer pointer, the two length fields, the cell header word and the trailer word into a context register set for the DMA data path. If the host still owns it, the block requests an idle cell and stays at the same ring position.

When the data path reports that the loaded buffer is finished, the block writes the first descriptor word back with ownership returned to the host. Once that write is accepted it moves to the next ring position, wrapping after a programmable entry count. For the last buffer of a packet it raises a one-cycle completion pulse, unless the descriptor asks for the interrupt to be suppressed.

Top module: `txr_fetch`

## Requirements
- R1: After a synchronous reset, `ctx_valid`, `mem_req`, `idle_cell` and `cmpl_irq` are 0, and the ring position is entry 0.
- R2: A descriptor fetch starts only when `fetch_en` is high while no buffer is loaded. While `ctx_valid` is 1, `fetch_en` has no effect and `mem_req` stays 0.
- R3: If bit 31 (ownership: 1 = device, 0 = host) of the head descriptor's first word is 0, then `idle_cell` pulses for one cycle, no context is loaded and the ring position does not change.
- R4: An owned descriptor is read as words 0 to 3 at addresses `ring_base + 4*index + word`. The block then raises `ctx_valid` with `ctx_ptr` = word 1, `ctx_hdr` = word 2, `ctx_trl` = word 3, `ctx_buf_len` = word 0 bits 15:0, `ctx_pkt_len` = bits 26:16, `ctx_sop` = bit 30, `ctx_eop` = bit 29, and `ctx_aal5` = 1 exactly when bit 27 is 0.
- R5: A `buf_done` pulse while loaded causes one write to `ring_base + 4*index`. The written word is the original word 0 with bit 31 cleared and every other bit unchanged.
- R6: While `mem_ready` is low, a pending request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady. The ring position advances only when the write-back is accepted.
- R7: After entry `ring_entries-1`, the next ring position is entry 0.
- R8: `cmpl_irq` pulses for one cycle, in the cycle after the write-back is accepted, only when the descriptor had bit 29 (last buffer) set and bit 28 (suppress) clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Word address of ring entry 0 |
| ring_entries | input | IDX_W+1 | Number of entries in the ring |
| fetch_en | input | 1 | Scheduler slot for this channel |
| buf_done | input | 1 | Data path finished the loaded buffer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after an accepted read |
| ctx_valid | output | 1 | A buffer is loaded |
| ctx_ptr | output | 32 | Buffer start pointer |
| ctx_hdr | output | 32 | Cell header word |
| ctx_trl | output | 32 | Trailer control and length word |
| ctx_buf_len | output | 16 | Buffer length |
| ctx_pkt_len | output | 11 | Packet length |
| ctx_sop | output | 1 | First buffer of packet |
| ctx_eop | output | 1 | Last buffer of packet |
| ctx_aal5 | output | 1 | Packet uses adaptation-layer-5 processing |
| idle_cell | output | 1 | One-cycle request to send an idle cell |
| cmpl_irq | output | 1 | One-cycle packet completion event |

## Verification
The bench builds the block with IDX_W = 3 and ADDR_W = 8, and drives `ring_entries` = 3 with the ring placed at word 16. A three-entry ring wraps after a handful of buffers, so the bench reaches the wrap back onto an entry that the host has already reclaimed. Its memory model can lower `mem_ready` on every other cycle, which lets the bench cover held requests both during descriptor reads and during the ownership write-back.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // Word-0 bit positions, decoded by the host side as well
  localparam int OWN_B  = 31;
  localparam int SOP_B  = 30;
  localparam int EOP_B  = 29;
  localparam int SUPP_B = 28;
  localparam int TYPE_B = 27;
  localparam int WORDS  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RDAT,
    ST_LOADED,
    ST_WB
  } txr_state_e;
endpackage

// File: rtl/txr_ring_idx.sv
module txr_ring_idx #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [IDX_W:0]   entries,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W:0] nxt;
  assign nxt = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (adv)
      idx <= (nxt >= entries) ? '0 : nxt[IDX_W-1:0];
  end
endmodule

// File: rtl/txr_ctx_regs.sv
module txr_ctx_regs
  import txr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load_en,
  input  logic [1:0]  wsel,
  input  logic [31:0] rdata,
  output logic [31:0] w0,
  output logic [31:0] ptr,
  output logic [31:0] hdr,
  output logic [31:0] trl
);
  logic [31:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[g] <= '0;
      else if (load_en && wsel == 2'(g))
        word_q[g] <= rdata;
    end
  end

  assign w0  = word_q[0];
  assign ptr = word_q[1];
  assign hdr = word_q[2];
  assign trl = word_q[3];
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
  import txr_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [IDX_W:0]    ring_entries,
  input  logic              fetch_en,
  input  logic              buf_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              ctx_valid,
  output logic [31:0]       ctx_ptr,
  output logic [31:0]       ctx_hdr,
  output logic [31:0]       ctx_trl,
  output logic [15:0]       ctx_buf_len,
  output logic [10:0]       ctx_pkt_len,
  output logic              ctx_sop,
  output logic              ctx_eop,
  output logic              ctx_aal5,
  output logic              idle_cell,
  output logic              cmpl_irq
);
  localparam int OFS_W = IDX_W + 2;

  txr_state_e       state_q;
  logic [1:0]       wsel_q;
  logic [IDX_W-1:0] idx;
  logic [31:0]      w0;
  logic             load_en;
  logic             adv;
  logic             idle_q;
  logic             irq_q;

  assign load_en = (state_q == ST_RDAT);
  assign adv     = (state_q == ST_WB) && mem_ready;

  txr_ring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .entries (ring_entries),
    .idx     (idx)
  );

  txr_ctx_regs u_ctx (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .wsel    (wsel_q),
    .rdata   (mem_rdata),
    .w0      (w0),
    .ptr     (ctx_ptr),
    .hdr     (ctx_hdr),
    .trl     (ctx_trl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wsel_q  <= '0;
      idle_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      idle_q <= 1'b0;
      irq_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          wsel_q <= '0;
          if (fetch_en) state_q <= ST_RD;
        end
        ST_RD: begin
          if (mem_ready) state_q <= ST_RDAT;
        end
        ST_RDAT: begin
          if (wsel_q == 2'd0 && !mem_rdata[OWN_B]) begin
            idle_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (wsel_q == 2'(WORDS - 1)) begin
            state_q <= ST_LOADED;
          end else begin
            wsel_q  <= wsel_q + 2'd1;
            state_q <= ST_RD;
          end
        end
        ST_LOADED: begin
          if (buf_done) begin
            wsel_q  <= '0;
            state_q <= ST_WB;
          end
        end
        ST_WB: begin
          if (mem_ready) begin
            irq_q   <= w0[EOP_B] && !w0[SUPP_B];
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req     = (state_q == ST_RD) || (state_q == ST_WB);
  assign mem_we      = (state_q == ST_WB);
  assign mem_addr    = ring_base + ADDR_W'({idx, wsel_q});
  assign mem_wdata   = w0 & ~(32'd1 << OWN_B);
  assign ctx_valid   = (state_q == ST_LOADED);
  assign ctx_buf_len = w0[15:0];
  assign ctx_pkt_len = w0[26:16];
  assign ctx_sop     = w0[SOP_B];
  assign ctx_eop     = w0[EOP_B];
  assign ctx_aal5    = !w0[TYPE_B];
  assign idle_cell   = idle_q;
  assign cmpl_irq    = irq_q;

  logic unused_ofs;
  assign unused_ofs = (OFS_W > ADDR_W);
endmodule

// File: rtl/txr_fetch_chk.sv
module txr_fetch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready,
  input logic              ctx_valid,
  input logic              idle_cell,
  input logic              cmpl_irq
);
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R6
  AST_NO_FETCH_LOADED: assert property (@(posedge clk) disable iff (rst)
    ctx_valid |-> !mem_req); // R2
  AST_IDLE_NOT_LOADED: assert property (@(posedge clk) disable iff (rst)
    idle_cell |-> !ctx_valid); // R3
  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[31]); // R5
  AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    cmpl_irq |-> $past(mem_req && mem_we && mem_ready)); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmpl_irq |=> !cmpl_irq); // R8
endmodule

bind txr_fetch txr_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .ctx_valid (ctx_valid),
  .idle_cell (idle_cell),
  .cmpl_irq  (cmpl_irq)
);

// File: tb/txr_fetch_test.sv
`timescale 1ns/1ps
module txr_fetch_test;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = 8;
  localparam int K_IDLE = 0, K_LOAD = 1, K_IRQ = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst = 1'b1;
  logic [ADDR_W-1:0] ring_base = 8'd16;
  logic [IDX_W:0]    ring_entries = 4'd3;
  logic              fetch_en = 1'b0, buf_done = 1'b0;
  logic              mem_req, mem_we, mem_ready;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              ctx_valid, ctx_sop, ctx_eop, ctx_aal5, idle_cell, cmpl_irq;
  logic [31:0]       ctx_ptr, ctx_hdr, ctx_trl;
  logic [15:0]       ctx_buf_len;
  logic [10:0]       ctx_pkt_len;

  txr_fetch #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) uut (.*);

  // memory model with optional every-other-cycle stall and a host write port
  logic [31:0]       mem [0:255];
  logic              tog = 1'b0, stall_en = 1'b0;
  logic              hw_en = 1'b0;
  logic [ADDR_W-1:0] hw_addr = '0;
  logic [31:0]       hw_data = '0;
  assign mem_ready = !stall_en || tog;
  always @(posedge clk) begin
    tog <= ~tog;
    if (hw_en) mem[hw_addr] <= hw_data;
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  typedef struct {
    int kind; string req;
    logic [31:0] ptr, hdr, trl;
    logic [15:0] blen; logic [10:0] plen;
    logic sop, eop, aal5;
  } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw0(bit own, bit sop, bit eop, bit supp, bit typ,
                                       logic [10:0] plen, logic [15:0] blen);
    return {own, sop, eop, supp, typ, plen, blen};
  endfunction

  task automatic host_put(int e, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
    logic [31:0] w [4];
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk);
      hw_en = 1'b1; hw_addr = ring_base + ADDR_W'(4 * e + i); hw_data = w[i];
    end
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic push_load(string req, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
    exp_t x;
    x.kind = K_LOAD; x.req = req; x.ptr = w1; x.hdr = w2; x.trl = w3;
    x.blen = w0[15:0]; x.plen = w0[26:16]; x.sop = w0[30]; x.eop = w0[29]; x.aal5 = !w0[27];
    q.push_back(x);
  endtask

  task automatic push_kind(int k, string req);
    exp_t x;
    x.kind = k; x.req = req; x.ptr = '0; x.hdr = '0; x.trl = '0;
    x.blen = '0; x.plen = '0; x.sop = 0; x.eop = 0; x.aal5 = 0;
    q.push_back(x);
  endtask

  task automatic slot();
    @(negedge clk) fetch_en = 1'b1;
    @(negedge clk) fetch_en = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic finish_buf();
    @(negedge clk) buf_done = 1'b1;
    @(negedge clk) buf_done = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // monitor: pops expected items as events appear
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (idle_cell || cmpl_irq || (ctx_valid && !prev_valid)) begin
        int k;
        exp_t x;
        k = idle_cell ? K_IDLE : (cmpl_irq ? K_IRQ : K_LOAD);
        if (q.size() == 0) begin
          chk(0, "R3/R8", "unexpected event kind", k, 32'hFFFF_FFFF);
        end else begin
          x = q.pop_front();
          chk(k == x.kind, x.req, "event kind", k, x.kind);
          if (k == K_LOAD && x.kind == K_LOAD) begin
            chk(ctx_ptr == x.ptr, x.req, "ctx_ptr", ctx_ptr, x.ptr);
            chk(ctx_hdr == x.hdr, x.req, "ctx_hdr", ctx_hdr, x.hdr);
            chk(ctx_trl == x.trl, x.req, "ctx_trl", ctx_trl, x.trl);
            chk({ctx_pkt_len, ctx_buf_len} == {x.plen, x.blen}, x.req, "lengths",
                {5'd0, ctx_pkt_len, ctx_buf_len}, {5'd0, x.plen, x.blen});
            chk({ctx_sop, ctx_eop, ctx_aal5} == {x.sop, x.eop, x.aal5}, x.req, "flags",
                {29'd0, ctx_sop, ctx_eop, ctx_aal5}, {29'd0, x.sop, x.eop, x.aal5});
          end
        end
      end
      prev_valid <= ctx_valid;
    end
  end

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] a0, b0, c0, d0;
    bit req_seen;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!ctx_valid, "R1", "ctx_valid", ctx_valid, 0);
    chk(!mem_req, "R1", "mem_req", mem_req, 0);
    chk(!idle_cell && !cmpl_irq, "R1", "pulses", {idle_cell, cmpl_irq}, 0);

    // R3: unowned head gives idle cell
    push_kind(K_IDLE, "R3");
    slot();

    // R3/R4: same entry 0 now owned, single-buffer packet, adaptation layer 5
    a0 = mkw0(1, 1, 1, 0, 0, 11'd100, 16'd100);
    host_put(0, a0, 32'hA000_0100, 32'h0012_3450, 32'h0000_0064);
    push_load("R4", a0, 32'hA000_0100, 32'h0012_3450, 32'h0000_0064);
    slot();

    // R2: slot while loaded is ignored
    req_seen = 0;
    @(negedge clk) fetch_en = 1'b1;
    @(negedge clk) fetch_en = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (mem_req) req_seen = 1;
    end
    chk(!req_seen && ctx_valid, "R2", "request while loaded", {30'd0, req_seen, ctx_valid}, 1);

    // R5/R8: done with last buffer, interrupt enabled
    push_kind(K_IRQ, "R8");
    finish_buf();
    chk(mem[16] == (a0 & 32'h7FFF_FFFF), "R5", "entry0 word0", mem[16], a0 & 32'h7FFF_FFFF);

    // entry 1: first buffer, not last, other type: no interrupt
    b0 = mkw0(1, 1, 0, 0, 1, 11'd200, 16'd64);
    host_put(1, b0, 32'hB000_0200, 32'h0045_6780, 32'h0000_00C8);
    push_load("R4", b0, 32'hB000_0200, 32'h0045_6780, 32'h0000_00C8);
    slot();
    finish_buf();
    chk(mem[20] == (b0 & 32'h7FFF_FFFF), "R5", "entry1 word0", mem[20], b0 & 32'h7FFF_FFFF);

    // R6/R8: stalled memory, last buffer with suppress flag
    stall_en = 1'b1;
    c0 = mkw0(1, 0, 1, 1, 0, 11'd200, 16'd136);
    host_put(2, c0, 32'hC000_0300, 32'h0078_9AB0, 32'h0000_00C8);
    push_load("R6", c0, 32'hC000_0300, 32'h0078_9AB0, 32'h0000_00C8);
    slot();
    finish_buf();
    chk(mem[24] == (c0 & 32'h7FFF_FFFF), "R6", "entry2 word0 under stall", mem[24], c0 & 32'h7FFF_FFFF);
    stall_en = 1'b0;

    // R7: wrap onto entry 0, reclaimed by host -> idle, then new content loads
    push_kind(K_IDLE, "R7");
    slot();
    d0 = mkw0(1, 1, 1, 0, 0, 11'd48, 16'd48);
    host_put(0, d0, 32'hD000_0400, 32'h00CD_EF00, 32'h0000_0030);
    push_load("R7", d0, 32'hD000_0400, 32'h00CD_EF00, 32'h0000_0030);
    slot();
    push_kind(K_IRQ, "R8");
    finish_buf();
    chk(mem[16] == (d0 & 32'h7FFF_FFFF), "R7", "entry0 word0 after wrap", mem[16], d0 & 32'h7FFF_FFFF);

    chk(q.size() == 0, "R8", "pending expected events", q.size(), 0);
    summary();
  end
endmodule